// File: doc/BRIEF.md
# Multi-channel countdown timer bank

This peripheral holds three auto-reloading down-counters and one free-running up-counter behind a small register bus. Two down-counters are narrow (16 bits by default) and one is wide (32 bits by default). Each down-counter steps on a tick enable that its own control word picks: a reference tick of roughly 508 kHz or a slow tick of roughly 2 kHz. When a down-counter underflows it raises a sticky, level-high interrupt line. Software drops that line by writing to the channel's clear register.

The fourth channel is a 40-bit up-counter by default. It advances on a faster tick of roughly 983 kHz while its enable bit is set, and it never interrupts. Its count is read in two parts. Reading the low word also captures the upper bits, so a following read of the high word returns bits that match the low word already returned. All ticks arrive as single-cycle enable pulses in the bus clock domain, and read data is combinational from the address.

Top module: `tick_timer_bank`

## Requirements
- R1: Channel blocks start at 0x00, 0x20 and 0x80. Within a block, offset +0x0 is the reload register (read/write), +0x4 is the live count (read only), +0x8 is control (read/write) and +0xC is clear (write only, reads zero). Control keeps only bit 7 (enable), bit 6 (periodic) and bit 3 (reference-tick select); its other bits read zero. Unmapped addresses read zero and ignore writes.
- R2: A write to the reload register stores the low channel-width bits of the write data. The same write places that value into the counter in the same cycle and overrides any tick in that cycle. Upper write bits are dropped and read back as zero.
- R3: While enable is set, the counter falls by one on each selected tick. While enable is clear, the counter holds its value whatever the ticks do.
- R4: With the select bit set the channel steps on tick_ref. With it clear the channel steps on tick_slow, and the other tick has no effect.
- R5: In periodic mode, a tick that finds the counter at zero reloads it from the reload register. A reload value of N therefore gives one underflow every N+1 selected ticks.
- R6: With periodic mode clear, a tick that finds the counter at zero wraps it to all ones of the channel width.
- R7: An underflow of channel k sets irq[k] (channel at 0x00 is bit 0, 0x20 bit 1, 0x80 bit 2). The flag stays high until a write of any value to that channel's clear register. An underflow in the same cycle as a clear write leaves the flag set.
- R8: The up-counter rises by one on each tick_fast while its enable is set. The enable is bit 8 of address 0x64 and is written from write-data bit 8. Writes to 0x60 have no effect, and the up-counter never drives irq.
- R9: A read strobe at 0x60 returns the live low LOW_W bits and captures the counter's upper FREE_W-LOW_W bits. Address 0x64 reads the enable at bit 8 and the captured upper bits at the bottom.
- R10: A synchronous active-low reset clears every counter, reload value, control word, interrupt flag, the up-counter, its enable and its captured upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ref | input | 1 | Reference-rate tick enable pulse |
| tick_slow | input | 1 | Slow-rate tick enable pulse |
| tick_fast | input | 1 | Up-counter tick enable pulse |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used to capture the up-counter's upper bits) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 3 | Sticky underflow flags, one per down-counter |

## Verification
The bench builds the bank with 8-bit narrow channels, a 12-bit wide channel and a 12-bit up-counter split 8/4. With these widths the wrap of a free-mode channel to all ones, the upper-bit difference between the narrow and wide channels and the carry from the low word into the captured high part all occur within a few hundred cycles. A behavioural model tracks every register. It is compared against the read data at the driven address and against irq on each cycle. Randomised traffic with small reload values keeps underflows, clear collisions and tick-select changes frequent.

// File: rtl/tick_timer_pkg.sv
// Shared constants, types and helpers for the countdown timer bank.
// Assumes a 32-bit data bus and byte addresses with channel blocks aligned to 16 bytes.
package tick_timer_pkg;

    localparam int DATA_W = 32;
    localparam int NUM_CH = 3;

    // Control bit positions inside a channel's control word
    localparam int CTRL_ENA_BIT = 7;
    localparam int CTRL_PER_BIT = 6;
    localparam int CTRL_SEL_BIT = 3;

    // Enable bit of the up-counter's high-word register
    localparam int FREE_EN_BIT = 8;

    // Register offsets inside a channel block
    localparam logic [3:0] OFS_LOAD  = 4'h0;
    localparam logic [3:0] OFS_VALUE = 4'h4;
    localparam logic [3:0] OFS_CTRL  = 4'h8;
    localparam logic [3:0] OFS_CLEAR = 4'hC;

    localparam logic [7:0] FREE_LO_ADDR = 8'h60;
    localparam logic [7:0] FREE_HI_ADDR = 8'h64;

    typedef struct packed {
        logic ena;
        logic per;
        logic sel;
    } chan_ctrl_t;

    // Block base address of down-counter number idx
    function automatic logic [7:0] chan_base(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction

    // Read-back image of a control word
    function automatic logic [DATA_W-1:0] ctrl_word(input chan_ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_ENA_BIT] = c.ena;
        w[CTRL_PER_BIT] = c.per;
        w[CTRL_SEL_BIT] = c.sel;
        return w;
    endfunction

endpackage

// File: rtl/tmr_down_chan.sv
// One auto-reloading down-counter with a sticky underflow flag.
// Assumes ticks are single-cycle enables; a reload write beats a tick in the
// same cycle, and an underflow beats a clear in the same cycle.
module tmr_down_chan
    import tick_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ref,
    input  logic             tick_slow,
    input  logic             load_wr,
    input  logic [W-1:0]     load_val,
    input  logic             ctrl_wr,
    input  chan_ctrl_t       ctrl_val,
    input  logic             clr_wr,
    output logic [W-1:0]     cnt_o,
    output logic [W-1:0]     reload_o,
    output chan_ctrl_t       ctrl_o,
    output logic             flag_o
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] reload_q;
    chan_ctrl_t   ctrl_q;
    logic         flag_q;
    logic         tick_sel;
    logic         step;
    logic         underflow;

    // Pick the tick this channel listens to and decide whether it steps
    always_comb begin
        tick_sel  = ctrl_q.sel ? tick_ref : tick_slow;
        step      = ctrl_q.ena && tick_sel && !load_wr;
        underflow = step && (cnt_q == '0);
    end

    // Counter: direct load, then decrement, reload or wrap on a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_wr) begin
            cnt_q <= load_val;
        end else if (step) begin
            if (cnt_q == '0) begin
                cnt_q <= ctrl_q.per ? reload_q : '1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Reload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (load_wr) begin
            reload_q <= load_val;
        end
    end

    // Control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_val;
        end
    end

    // Sticky interrupt flag, underflow has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (underflow) begin
            flag_q <= 1'b1;
        end else if (clr_wr) begin
            flag_q <= 1'b0;
        end
    end

    assign cnt_o    = cnt_q;
    assign reload_o = reload_q;
    assign ctrl_o   = ctrl_q;
    assign flag_o   = flag_q;

    // R2: a reload write lands in the counter on the next cycle
    a_r2_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (cnt_q == $past(load_val)));

    // R3: a disabled channel without a reload write keeps its count
    a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.ena && !load_wr) |=> $stable(cnt_q));

    // R5: periodic underflow restores the reload value
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ena && ctrl_q.per && tick_sel && !load_wr && cnt_q == '0)
        |=> (cnt_q == $past(reload_q)));

    // R6: free-mode underflow wraps to all ones
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ena && !ctrl_q.per && tick_sel && !load_wr && cnt_q == '0)
        |=> (&cnt_q));

    // R7: a raised flag survives any cycle without a clear write
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_wr) |=> flag_q);

    // R7: an underflow always leaves the flag high, even with a clear
    a_r7_uf_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.ena && tick_sel && !load_wr && cnt_q == '0) |=> flag_o);

endmodule

// File: rtl/tmr_free_cnt.sv
// Free-running up-counter with an enable bit and a capture of its upper bits.
// Assumes 1 <= FREE_W-LOW_W <= 8 and LOW_W <= 32; the capture is taken when
// the low word is read so a later high read matches it.
module tmr_free_cnt #(
    parameter int FREE_W = 40,
    parameter int LOW_W  = 32,
    localparam int HIGH_W = FREE_W - LOW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast,
    input  logic              en_wr,
    input  logic              en_val,
    input  logic              snap_rd,
    output logic [LOW_W-1:0]  lo_o,
    output logic              en_o,
    output logic [HIGH_W-1:0] snap_o
);

    logic [FREE_W-1:0] cnt_q;
    logic              en_q;
    logic [HIGH_W-1:0] snap_q;

    // Up-count on each fast tick while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en_q && tick_fast) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Enable bit, written through the high-word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= en_val;
        end
    end

    // Capture the upper bits when the low word is read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (snap_rd) begin
            snap_q <= cnt_q[FREE_W-1:LOW_W];
        end
    end

    assign lo_o   = cnt_q[LOW_W-1:0];
    assign en_o   = en_q;
    assign snap_o = snap_q;

    // R8: each enabled tick adds exactly one
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick_fast) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8: a disabled counter holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> $stable(cnt_q));

    // R9: the capture matches the upper bits seen at the low read
    a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_rd |=> (snap_q == $past(cnt_q[FREE_W-1:LOW_W])));

endmodule

// File: rtl/tick_timer_bank.sv
// Timer bank top: address decode, three down-counters of mixed width and one
// up-counter with a split read. Assumes one bus access per cycle and that all
// ticks are single-cycle enables in the clk domain. Read data is combinational.
module tick_timer_bank
    import tick_timer_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int FREE_W   = 40,
    parameter int LOW_W    = 32,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ref,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int HIGH_W = FREE_W - LOW_W;

    logic [3:0]        ofs;
    logic [ADDR_W-5:0] blk;
    logic [DATA_W-1:0] ch_rd [NUM_CH];
    chan_ctrl_t        wr_ctrl;

    // Split the address into block and offset; shape the control write image
    always_comb begin
        ofs         = bus_addr[3:0];
        blk         = bus_addr[ADDR_W-1:4];
        wr_ctrl.ena = bus_wdata[CTRL_ENA_BIT];
        wr_ctrl.per = bus_wdata[CTRL_PER_BIT];
        wr_ctrl.sel = bus_wdata[CTRL_SEL_BIT];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam int W = (g == NUM_CH - 1) ? WIDE_W : NARROW_W;
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(chan_base(g));

        logic         hit;
        logic [W-1:0] cnt;
        logic [W-1:0] reload;
        chan_ctrl_t   ctl;
        logic         flag;

        assign hit = (blk == BASE[ADDR_W-1:4]);

        tmr_down_chan #(.W(W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_ref  (tick_ref),
            .tick_slow (tick_slow),
            .load_wr   (bus_wr && hit && ofs == OFS_LOAD),
            .load_val  (bus_wdata[W-1:0]),
            .ctrl_wr   (bus_wr && hit && ofs == OFS_CTRL),
            .ctrl_val  (wr_ctrl),
            .clr_wr    (bus_wr && hit && ofs == OFS_CLEAR),
            .cnt_o     (cnt),
            .reload_o  (reload),
            .ctrl_o    (ctl),
            .flag_o    (flag)
        );

        // Read image of this channel's block
        always_comb begin
            ch_rd[g] = '0;
            if (hit) begin
                case (ofs)
                    OFS_LOAD:  ch_rd[g] = DATA_W'(reload);
                    OFS_VALUE: ch_rd[g] = DATA_W'(cnt);
                    OFS_CTRL:  ch_rd[g] = ctrl_word(ctl);
                    default:   ch_rd[g] = '0;
                endcase
            end
        end

        assign irq[g] = flag;
    end

    logic              lo_hit;
    logic              hi_hit;
    logic [LOW_W-1:0]  free_lo;
    logic              free_en;
    logic [HIGH_W-1:0] free_snap;

    assign lo_hit = (bus_addr == ADDR_W'(FREE_LO_ADDR));
    assign hi_hit = (bus_addr == ADDR_W'(FREE_HI_ADDR));

    tmr_free_cnt #(.FREE_W(FREE_W), .LOW_W(LOW_W)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_fast (tick_fast),
        .en_wr     (bus_wr && hi_hit),
        .en_val    (bus_wdata[FREE_EN_BIT]),
        .snap_rd   (bus_rd && lo_hit),
        .lo_o      (free_lo),
        .en_o      (free_en),
        .snap_o    (free_snap)
    );

    // Merge the up-counter words and the channel blocks into the read data
    always_comb begin
        logic [DATA_W-1:0] rd;
        if (lo_hit) begin
            rd = DATA_W'(free_lo);
        end else if (hi_hit) begin
            rd = (DATA_W'(free_en) << FREE_EN_BIT) | DATA_W'(free_snap);
        end else begin
            rd = '0;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            rd = rd | ch_rd[i];
        end
        bus_rdata = rd;
    end

endmodule

// File: tb/sim_tick_timer_bank.sv
`timescale 1ns/1ps
module sim_tick_timer_bank;

    localparam int NW = 8;
    localparam int WW = 12;
    localparam int FW = 12;
    localparam int LW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ref = 1'b0, tick_slow = 1'b0, tick_fast = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    tick_timer_bank #(.NARROW_W(NW), .WIDE_W(WW), .FREE_W(FW), .LOW_W(LW), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_ref(tick_ref), .tick_slow(tick_slow),
        .tick_fast(tick_fast), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    int  nvec = 0;
    int  nfail = 0;
    int  cyc = 0;
    bit  started = 0;
    bit  done = 0;

    // Behavioural reference model
    longint m_cnt [3];
    longint m_ld  [3];
    bit     m_en  [3];
    bit     m_pe  [3];
    bit     m_cs  [3];
    bit     m_fl  [3];
    longint m_free;
    bit     m_fen;
    longint m_snap;

    function automatic longint base_of(int i);
        return (i == 0) ? 'h00 : (i == 1) ? 'h20 : 'h80;
    endfunction

    function automatic longint mask_of(int i);
        return (i == 2) ? ((64'd1 << WW) - 1) : ((64'd1 << NW) - 1);
    endfunction

    always @(posedge clk) begin
        bit lw, cw, kw, tk, uf, blk;
        cyc++;
        started = 1;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_cnt[i] = 0; m_ld[i] = 0; m_en[i] = 0; m_pe[i] = 0; m_cs[i] = 0; m_fl[i] = 0;
            end
            m_free = 0; m_fen = 0; m_snap = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                blk = ((bus_addr & 8'hF0) == base_of(i));
                lw  = bus_wr && blk && bus_addr[3:0] == 4'h0;
                cw  = bus_wr && blk && bus_addr[3:0] == 4'h8;
                kw  = bus_wr && blk && bus_addr[3:0] == 4'hC;
                tk  = m_cs[i] ? tick_ref : tick_slow;
                uf  = 0;
                if (lw) begin
                    m_ld[i]  = bus_wdata & mask_of(i);
                    m_cnt[i] = m_ld[i];
                end else if (m_en[i] && tk) begin
                    if (m_cnt[i] == 0) begin
                        uf = 1;
                        m_cnt[i] = m_pe[i] ? m_ld[i] : mask_of(i);
                    end else begin
                        m_cnt[i] = m_cnt[i] - 1;
                    end
                end
                if (uf) m_fl[i] = 1;
                else if (kw) m_fl[i] = 0;
                if (cw) begin
                    m_en[i] = bus_wdata[7]; m_pe[i] = bus_wdata[6]; m_cs[i] = bus_wdata[3];
                end
            end
            if (bus_rd && bus_addr == 8'h60) m_snap = m_free >> LW;
            if (m_fen && tick_fast) m_free = (m_free + 1) & ((64'd1 << FW) - 1);
            if (bus_wr && bus_addr == 8'h64) m_fen = bus_wdata[8];
        end
    end

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        longint r;
        r = 0;
        for (int i = 0; i < 3; i++) begin
            if ((a & 8'hF0) == base_of(i)) begin
                case (a[3:0])
                    4'h0: r = m_ld[i];
                    4'h4: r = m_cnt[i];
                    4'h8: r = (longint'(m_en[i]) << 7) | (longint'(m_pe[i]) << 6) | (longint'(m_cs[i]) << 3);
                    default: r = 0;
                endcase
            end
        end
        if (a == 8'h60) r = m_free & ((64'd1 << LW) - 1);
        if (a == 8'h64) r = (longint'(m_fen) << 8) | m_snap;
        return 32'(r);
    endfunction

    function automatic string req_of(logic [7:0] a);
        if (a == 8'h60 || a == 8'h64) return "R9";
        if (a[3:0] == 4'h4) return "R3";
        return "R1";
    endfunction

    // Every-cycle comparison of read data and interrupt lines against the model
    always @(negedge clk) begin
        logic [31:0] e;
        if (started && !done) begin
            e = exp_rd(bus_addr);
            nvec++;
            if (bus_rdata !== e) begin
                nfail++;
                $display("FAIL %s rdata addr=%h act=%h exp=%h", req_of(bus_addr), bus_addr, bus_rdata, e);
            end
            nvec++;
            if (irq !== {m_fl[2], m_fl[1], m_fl[0]}) begin
                nfail++;
                $display("FAIL R7 irq act=%b exp=%b", irq, {m_fl[2], m_fl[1], m_fl[0]});
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic put(bit wr, bit rd, logic [7:0] a, logic [31:0] d, bit tr, bit ts, bit tf);
        @(posedge clk);
        #1;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        tick_ref = tr; tick_slow = ts; tick_fast = tf;
    endtask

    task automatic look(logic [7:0] a);
        put(0, 0, a, 0, 0, 0, 0);
        @(negedge clk);
    endtask

    task automatic period_test(int ch, logic [7:0] base, int n, string req);
        int  t [3];
        int  k = 0;
        bit  was = 0;
        bit  clr = 0;
        put(1, 0, base + 8'h08, 0, 0, 0, 0);
        put(1, 0, base + 8'h0C, 0, 0, 0, 0);
        put(1, 0, base, n, 0, 0, 0);
        put(1, 0, base + 8'h08, 32'hC8, 0, 0, 0);
        for (int c = 0; c < 300 && k < 3; c++) begin
            put(clr, 0, clr ? base + 8'h0C : base + 8'h04, 0, 1, 0, 0);
            clr = 0;
            @(negedge clk);
            if (irq[ch] && !was) begin
                t[k] = cyc;
                k++;
                clr = 1;
            end
            was = irq[ch];
        end
        chk(req, 32'(k), 32'd3);
        chk(req, 32'(t[1] - t[0]), 32'(n + 1));
        chk(req, 32'(t[2] - t[1]), 32'(n + 1));
        put(1, 0, base + 8'h08, 0, 0, 0, 0);
        put(1, 0, base + 8'h0C, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state
        look(8'h08); chk("R10", bus_rdata, 32'h0); chk("R10", 32'(irq), 32'h0);
        look(8'h64); chk("R10", bus_rdata, 32'h0);
        look(8'h84); chk("R10", bus_rdata, 32'h0);

        // R1: control read-back keeps only bits 7, 6, 3; clear and unmapped read zero
        put(1, 0, 8'h08, 32'hFFFF_FFFF, 0, 0, 0);
        look(8'h08); chk("R1", bus_rdata, 32'hC8);
        put(1, 0, 8'h08, 0, 0, 0, 0);
        look(8'h0C); chk("R1", bus_rdata, 32'h0);
        put(1, 0, 8'h44, 32'hFFFF_FFFF, 0, 0, 0);
        look(8'h40); chk("R1", bus_rdata, 32'h0);

        // R2: reload write truncates to channel width and loads the counter
        put(1, 0, 8'h00, 32'h1234, 0, 0, 0);
        look(8'h00); chk("R2", bus_rdata, 32'h34);
        look(8'h04); chk("R2", bus_rdata, 32'h34);
        put(1, 0, 8'h80, 32'hABCDE, 0, 0, 0);
        look(8'h84); chk("R2", bus_rdata, 32'hCDE);
        put(1, 0, 8'h28, 32'h88, 0, 0, 0);
        put(1, 0, 8'h20, 32'd10, 1, 0, 0);
        look(8'h24); chk("R2", bus_rdata, 32'd10);

        // R4 / R3: tick selection, stepping and hold when disabled
        put(1, 0, 8'h28, 32'h80, 0, 0, 0);
        put(0, 0, 8'h24, 0, 1, 0, 0);
        look(8'h24); chk("R4", bus_rdata, 32'd10);
        put(0, 0, 8'h24, 0, 0, 1, 0);
        look(8'h24); chk("R4", bus_rdata, 32'd9);
        put(1, 0, 8'h28, 32'h88, 0, 0, 0);
        put(0, 0, 8'h24, 0, 0, 1, 0);
        look(8'h24); chk("R4", bus_rdata, 32'd9);
        put(0, 0, 8'h24, 0, 1, 0, 0);
        look(8'h24); chk("R3", bus_rdata, 32'd8);
        put(1, 0, 8'h28, 32'h0, 0, 0, 0);
        put(0, 0, 8'h24, 0, 1, 1, 0);
        look(8'h24); chk("R3", bus_rdata, 32'd8);

        // R6: free mode wraps to all ones and raises the flag
        put(1, 0, 8'h08, 32'h88, 0, 0, 0);
        put(1, 0, 8'h00, 32'h0, 0, 0, 0);
        put(0, 0, 8'h04, 0, 1, 0, 0);
        look(8'h04); chk("R6", bus_rdata, 32'hFF); chk("R7", 32'(irq[0]), 32'd1);

        // R7: underflow in the same cycle as a clear keeps the flag
        put(1, 0, 8'h08, 32'hC8, 0, 0, 0);
        put(1, 0, 8'h00, 32'h0, 0, 0, 0);
        put(1, 0, 8'h0C, 32'h0, 1, 0, 0);
        look(8'h04); chk("R7", 32'(irq[0]), 32'd1);
        put(1, 0, 8'h0C, 32'h5A, 0, 0, 0);
        look(8'h04); chk("R7", 32'(irq[0]), 32'd0);
        put(1, 0, 8'h08, 32'h0, 0, 0, 0);

        // R5: underflow spacing equals reload + 1 ticks
        period_test(1, 8'h20, 3, "R5");
        period_test(2, 8'h80, 5, "R5");

        // R8 / R9: up-counter, split read, enable, ignored low-word write
        put(1, 0, 8'h64, 32'h100, 0, 0, 0);
        for (int i = 0; i < 300; i++) put(0, 0, 8'h60, 0, 0, 0, 1);
        put(0, 1, 8'h60, 0, 0, 0, 0);
        @(negedge clk); chk("R9", bus_rdata, 32'h2C);
        put(0, 1, 8'h64, 0, 0, 0, 0);
        @(negedge clk); chk("R9", bus_rdata, 32'h101);
        put(1, 0, 8'h64, 32'h0, 0, 0, 0);
        for (int i = 0; i < 5; i++) put(0, 0, 8'h60, 0, 0, 0, 1);
        put(1, 0, 8'h60, 32'hFF, 0, 0, 1);
        look(8'h60); chk("R8", bus_rdata, 32'h2C);
        look(8'h64); chk("R8", bus_rdata, 32'h1);

        // Randomised traffic compared against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int          pick;
            pick = $urandom_range(0, 13);
            case (pick)
                0: a = 8'h00;  1: a = 8'h04;  2: a = 8'h08;  3: a = 8'h0C;
                4: a = 8'h20;  5: a = 8'h24;  6: a = 8'h28;  7: a = 8'h2C;
                8: a = 8'h80;  9: a = 8'h84; 10: a = 8'h88; 11: a = 8'h8C;
                12: a = 8'h60; default: a = 8'h64;
            endcase
            d = $urandom;
            if (a[3:0] == 4'h0 && a != 8'h60) d = $urandom_range(0, 6);
            if (a[3:0] == 4'h8 && $urandom_range(0, 3) != 0) d[7] = 1'b1;
            put($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, a, d,
                $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0, $urandom_range(0, 1) == 1);
        end
        put(0, 0, 8'h00, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule